// File: doc/BRIEF.md
# AHB Slave Front End with Programmable Wait States

This block sits on the slave side of an AHB bus. In every address phase where it is selected and the bus is ready, it samples the transfer type, address, direction and size, and decides whether a real access will follow. Idle and busy slots get an immediate OKAY with no stall and never touch storage. Non-sequential and sequential beats read or write a small word array with byte lanes, and the data phase is stretched by a number of wait states taken from a configuration input.

The data phase handshake is registered. The ready output comes out of reset high and drops only for real accesses that need waits. The response is always OKAY. A write lands on the edge that closes its data phase. A read that directly follows a write to the same word returns the new bytes.

Top module: `ahb_wait_slave`

## Requirements
- R1: After reset, `ready_out_o` is 1 and `resp_o` is 0.
- R2: A selected transfer with type 00 (idle) completes with zero wait states and leaves storage unchanged, even when write is 1.
- R3: A selected transfer with type 01 (busy) completes with zero wait states and leaves storage unchanged, even when write is 1.
- R4: Types 10 (non-sequential) and 11 (sequential) are real accesses. A write stores `wdata_i` sampled in its data phase, and a later read of that word returns it on `rdata_o`.
- R5: With `wait_cfg_i` = N > 0 at capture, `ready_out_o` is low for exactly N cycles starting the cycle after capture, then high for the completing cycle.
- R6: With `wait_cfg_i` = 0 at capture, a real access completes in a single data-phase cycle.
- R7: The address-phase inputs are taken only when `sel_i` and `ready_in_i` are both 1. A real write presented with `sel_i` = 0 stores nothing and causes no stall.
- R8: `resp_o` is 0 (OKAY) in every cycle.
- R9: Byte lanes follow size and address. Size 0 writes one byte, size 1 writes a halfword, and size 2 or more writes the whole word. The lanes start at the address bits below the word index, aligned down to the size, and lane k is `wdata_i[8k+7:8k]`. Other lanes keep their old value.
- R10: A read captured on the same edge that commits a write to the same word returns the newly written lanes merged with the old ones.
- R11: `wait_cfg_i` is sampled only at capture. Changing it during a stretch does not alter that stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Slave select |
| trans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| addr_i | input | ADDR_W | Byte address; word index = bits above the byte offset, modulo DEPTH |
| write_i | input | 1 | 1 write, 0 read |
| size_i | input | 3 | log2 of the transfer byte count |
| wdata_i | input | DATA_W | Write data, valid in the data phase |
| ready_in_i | input | 1 | Bus ready, the previous data phase is finishing |
| wait_cfg_i | input | WAIT_W | Wait states for real accesses |
| ready_out_o | output | 1 | Data phase completes when high |
| resp_o | output | 1 | Response, 0 = OKAY |
| rdata_o | output | DATA_W | Read data, valid while `ready_out_o` is high in a read data phase |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=8, DEPTH=16 and WAIT_W=3. This makes the whole array small enough to fill and read back, and it allows stretches of up to seven cycles, including the largest value the configuration field can hold. The bench ties the bus ready back to the block's own ready output. As a result, a stalled data phase overlaps the next address phase, which lets it change the wait setting mid-stretch and issue a read on the same edge a write commits.

// File: rtl/ahbfe_pkg.sv
package ahbfe_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  // A slot moves data only for the two transfer types.
  function automatic logic is_access(input trans_e t);
    return (t == TR_NSEQ) || (t == TR_SEQ);
  endfunction

endpackage

// File: rtl/afe_capture.sv
module afe_capture #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6,
  parameter int LANES  = 4,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              acc_now,
  input  logic              done,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [2:0]        size,
  output logic [IDX_W-1:0]  idx_now,
  output logic              dp_valid,
  output logic              dp_write,
  output logic [IDX_W-1:0]  dp_idx,
  output logic [LANES-1:0]  dp_strb
);

  logic [LANES-1:0] strb_now;
  logic             unused_addr_hi;

  assign idx_now        = addr[OFS_W +: IDX_W];
  assign unused_addr_hi = ^addr[ADDR_W-1:OFS_W+IDX_W];

  // Lane enables: span from size, start aligned down to the span.
  always_comb begin
    int span;
    int base;
    span = (int'(size) >= OFS_W) ? LANES : (1 << int'(size));
    base = int'(addr[OFS_W-1:0]) & ~(span - 1);
    for (int i = 0; i < LANES; i++) begin
      strb_now[i] = (i >= base) && (i < base + span);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_idx   <= '0;
      dp_strb  <= '0;
    end else if (done) begin
      if (take) begin
        dp_valid <= acc_now;
        dp_write <= write;
        dp_idx   <= idx_now;
        dp_strb  <= strb_now;
      end else begin
        dp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/afe_waitgen.sv
module afe_waitgen #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              acc_now,
  input  logic [WAIT_W-1:0] wait_n,
  output logic              ready_q
);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      cnt     <= '0;
    end else if (ready_q) begin
      if (take && acc_now && (wait_n != '0)) begin
        ready_q <= 1'b0;
        cnt     <= wait_n;
      end
    end else begin
      if (cnt == WAIT_W'(1)) ready_q <= 1'b1;
      cnt <= cnt - WAIT_W'(1);
    end
  end

endmodule

// File: rtl/afe_regarray.sv
module afe_regarray #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_strb,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_strb[b]) mem[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  // Read-first registered port; held while rd_en is low.
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

endmodule

// File: rtl/ahb_wait_slave.sv
module ahb_wait_slave
  import ahbfe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 64,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic [1:0]        trans_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_in_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic              ready_out_o,
  output logic              resp_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam int IDX_W = $clog2(DEPTH);

  logic              take;
  logic              acc_now;
  logic [IDX_W-1:0]  idx_now;
  logic              dp_valid;
  logic              dp_write;
  logic [IDX_W-1:0]  dp_idx;
  logic [LANES-1:0]  dp_strb;
  logic              rd_en;
  logic              wr_en;
  logic [DATA_W-1:0] rd_q;
  logic [LANES-1:0]  fwd_strb;
  logic [DATA_W-1:0] fwd_data;

  assign take    = sel_i & ready_in_i & ready_out_o;
  assign acc_now = is_access(trans_e'(trans_i));
  assign rd_en   = take & acc_now & ~write_i;
  assign wr_en   = dp_valid & dp_write & ready_out_o;
  assign resp_o  = 1'b0;

  afe_capture #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANES(LANES), .OFS_W(OFS_W)
  ) u_capture (
    .clk(clk), .rst(rst), .take(take), .acc_now(acc_now), .done(ready_out_o),
    .addr(addr_i), .write(write_i), .size(size_i), .idx_now(idx_now),
    .dp_valid(dp_valid), .dp_write(dp_write), .dp_idx(dp_idx), .dp_strb(dp_strb)
  );

  afe_waitgen #(.WAIT_W(WAIT_W)) u_waitgen (
    .clk(clk), .rst(rst), .take(take), .acc_now(acc_now),
    .wait_n(wait_cfg_i), .ready_q(ready_out_o)
  );

  afe_regarray #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .LANES(LANES)
  ) u_array (
    .clk(clk), .rd_en(rd_en), .rd_idx(idx_now), .rd_q(rd_q),
    .wr_en(wr_en), .wr_idx(dp_idx), .wr_strb(dp_strb), .wr_data(wdata_i)
  );

  // Forward lanes of a write committing on the same edge as a read capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_strb <= '0;
      fwd_data <= '0;
    end else if (rd_en) begin
      fwd_strb <= (wr_en && (dp_idx == idx_now)) ? dp_strb : '0;
      fwd_data <= wdata_i;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rdata_o[g*8 +: 8] = fwd_strb[g] ? fwd_data[g*8 +: 8] : rd_q[g*8 +: 8];
    end
  endgenerate

endmodule

// File: rtl/afe_checker.sv
module afe_checker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_i,
  input logic              trans_hi,
  input logic              ready_in_i,
  input logic              ready_out_o,
  input logic [WAIT_W-1:0] wait_cfg_i
);

  logic              take;
  logic [WAIT_W:0]   lowcnt;
  logic [WAIT_W-1:0] cap_cfg;

  assign take = sel_i && ready_in_i && ready_out_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowcnt  <= '0;
      cap_cfg <= '0;
    end else begin
      if (take && trans_hi) cap_cfg <= wait_cfg_i;
      lowcnt <= ready_out_o ? '0 : lowcnt + 1'b1;
    end
  end

  assert_idle_busy_nowait_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !trans_hi) |=> ready_out_o);

  assert_zero_cfg_single_R6: assert property (@(posedge clk) disable iff (rst)
    (take && trans_hi && (wait_cfg_i == '0)) |=> ready_out_o);

  assert_stretch_begins_R5: assert property (@(posedge clk) disable iff (rst)
    (take && trans_hi && (wait_cfg_i != '0)) |=> !ready_out_o);

  assert_stretch_bounded_R11: assert property (@(posedge clk) disable iff (rst)
    !ready_out_o |-> (lowcnt < {1'b0, cap_cfg}));

  assert_unselected_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (!sel_i && ready_out_o) |=> ready_out_o);

endmodule

bind ahb_wait_slave afe_checker #(.WAIT_W(WAIT_W)) u_afe_checker (
  .clk(clk), .rst(rst), .sel_i(sel_i), .trans_hi(trans_i[1]),
  .ready_in_i(ready_in_i), .ready_out_o(ready_out_o), .wait_cfg_i(wait_cfg_i)
);

// File: tb/test_ahb_wait_slave.sv
module test_ahb_wait_slave;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 16;
  localparam int WAIT_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel_i = 1'b0;
  logic [1:0]        trans_i = 2'b00;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              write_i = 1'b0;
  logic [2:0]        size_i = 3'd2;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [WAIT_W-1:0] wait_cfg_i = '0;
  logic              ready_in_i;
  logic              ready_out_o;
  logic              resp_o;
  logic [DATA_W-1:0] rdata_o;

  always #5 clk = ~clk;
  assign ready_in_i = ready_out_o;

  ahb_wait_slave #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WAIT_W(WAIT_W)
  ) i_ahb_wait_slave (
    .clk(clk), .rst(rst), .sel_i(sel_i), .trans_i(trans_i), .addr_i(addr_i),
    .write_i(write_i), .size_i(size_i), .wdata_i(wdata_i), .ready_in_i(ready_in_i),
    .wait_cfg_i(wait_cfg_i), .ready_out_o(ready_out_o), .resp_o(resp_o), .rdata_o(rdata_o)
  );

  int vectors = 0;
  int fails   = 0;
  logic [DATA_W-1:0] model [DEPTH];
  int          q_waits [$];
  bit          q_rd    [$];
  logic [31:0] q_data  [$];
  string       q_tag   [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input int a, input int sz);
    logic [31:0] r;
    int span;
    int base;
    r    = old;
    span = (sz >= 2) ? 4 : (1 << sz);
    base = (a % 4) & ~(span - 1);
    for (int b = 0; b < 4; b++)
      if (b >= base && b < base + span) r[b*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  // Driver: present one address phase, push the expected result when captured.
  task automatic xfer(input logic [1:0] tr, input int a, input bit wr, input int sz,
                      input logic [31:0] wd, input int cfg, input string tag);
    int idx;
    sel_i = 1'b1; trans_i = tr; addr_i = ADDR_W'(a); write_i = wr;
    size_i = 3'(sz); wait_cfg_i = WAIT_W'(cfg);
    do @(negedge clk); while (!ready_out_o);
    idx = (a / 4) % DEPTH;
    q_waits.push_back(tr[1] ? cfg : 0);
    q_rd.push_back(tr[1] && !wr);
    q_data.push_back(model[idx]);
    q_tag.push_back(tag);
    if (tr[1] && wr) model[idx] = merge(model[idx], wd, a, sz);
    @(posedge clk); #1;
    wdata_i = wd;
  endtask

  task automatic unsel(input int a, input logic [31:0] wd);
    sel_i = 1'b0; trans_i = 2'b10; addr_i = ADDR_W'(a); write_i = 1'b1; size_i = 3'd2;
    do @(negedge clk); while (!ready_out_o);
    @(posedge clk); #1;
    wdata_i = wd;
  endtask

  // Monitor: counts stall cycles per data phase and compares with the queue.
  bit act_dp = 1'b0;
  int lows   = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (act_dp) begin
          if (!ready_out_o) lows++;
          else begin
            if (q_waits.size() == 0) begin
              vectors++; fails++;
              $display("FAIL R4 actual=unexpected data phase expected=none");
            end else begin
              string t;
              int w;
              bit r;
              logic [31:0] d;
              t = q_tag.pop_front(); w = q_waits.pop_front();
              r = q_rd.pop_front();  d = q_data.pop_front();
              check({t, " wait count"}, 32'(lows), 32'(w));
              check("R8 response", {31'd0, resp_o}, 32'd0);
              if (r) check({t, " read data"}, rdata_o, d);
            end
            act_dp = 1'b0;
          end
        end
        if (sel_i && ready_out_o) begin
          act_dp = 1'b1;
          lows   = 0;
        end
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, ready_out_o}, 32'd1);
    check("R1 resp after reset", {31'd0, resp_o}, 32'd0);
    @(posedge clk); #1;

    // R4: fill every word with a burst, then read back.
    for (int i = 0; i < DEPTH; i++)
      xfer(i == 0 ? 2'b10 : 2'b11, i*4, 1'b1, 2, 32'hA500_0000 + 32'(i), 0, "R4");
    for (int i = 0; i < 4; i++)
      xfer(i == 0 ? 2'b10 : 2'b11, i*4, 1'b0, 2, 32'h0, 0, "R6");

    // R5 and R11: stretched accesses with the setting changed mid-stretch.
    xfer(2'b10, 8,  1'b0, 2, 32'h0, 3, "R5");
    xfer(2'b10, 12, 1'b0, 2, 32'h0, 0, "R11");
    xfer(2'b10, 16, 1'b1, 2, 32'h1234_5678, 7, "R5");
    xfer(2'b10, 16, 1'b0, 2, 32'h0, 1, "R5");

    // R2/R3: idle and busy writes are ignored and never stall.
    xfer(2'b00, 20, 1'b1, 2, 32'hDEAD_0001, 5, "R2");
    xfer(2'b01, 24, 1'b1, 2, 32'hDEAD_0002, 4, "R3");
    xfer(2'b10, 20, 1'b0, 2, 32'h0, 0, "R2");
    xfer(2'b10, 24, 1'b0, 2, 32'h0, 2, "R3");

    // R7: unselected write does nothing.
    unsel(28, 32'hBEEF_BEEF);
    xfer(2'b10, 28, 1'b0, 2, 32'h0, 0, "R7");

    // R9: byte and halfword lanes.
    xfer(2'b10, 33, 1'b1, 0, 32'h1122_3344, 0, "R9");
    xfer(2'b10, 38, 1'b1, 1, 32'h5566_7788, 2, "R9");
    xfer(2'b10, 32, 1'b0, 2, 32'h0, 0, "R9");

    // R10: read right behind a write to the same word.
    xfer(2'b10, 40, 1'b1, 2, 32'hC0DE_F00D, 0, "R10");
    xfer(2'b10, 40, 1'b0, 2, 32'h0, 0, "R10");
    xfer(2'b10, 43, 1'b1, 0, 32'h9900_0000, 1, "R10");
    xfer(2'b10, 40, 1'b0, 2, 32'h0, 0, "R10");

    sel_i = 1'b0; trans_i = 2'b00;
    repeat (12) @(posedge clk);
    check("R4 scoreboard drained", 32'(q_waits.size()), 32'd0);
    summary();
    $finish;
  end

endmodule